// File: doc/BRIEF.md
# Rearrangeable Benes Permutation Network

This block is an N-lane data switch built only from 2x2 switching elements. The elements are arranged as a Benes network. An N-lane network is a column of N/2 elements on the input side, two N/2-lane networks of the same kind, and a column of N/2 elements on the output side. The halves are split again until each one is a single element. This gives 2·log2(N)−1 columns of N/2 elements. With the default N=8, that is five columns of four elements, or twenty elements.

Each element has a 2-bit control code. The code makes the element pass its inputs straight through, swap them, or copy one input to both outputs. Because the network is rearrangeable, some set of codes realises any permutation of lanes. Because the elements can copy, every one of the N^N lane-to-lane mappings can also be reached.

Software or a sequencer writes the codes one element at a time into a staging bank. A load strobe then copies the whole bank into the active bank that steers the data path. The data path is combinational. A parameter can add one output register after it. Working out the codes for a wanted mapping is done outside the block.

Top module: `benes_net`

## Requirements
- R1: Reset is synchronous and active high. It sets every staging and active code to 00. With the output register present, it also clears `dout` to zero.
- R2: Each element has an upper input and a lower input, and two outputs. Its code selects the outputs as follows:
  - 00: pass, so upper goes to upper and lower goes to lower.
  - 01: swap.
  - 10: both outputs carry the upper input.
  - 11: both outputs carry the lower input.
- R3: Placement and wiring of the elements:
  - Columns are numbered 0 (input side) to 2·log2(N)−2. Element k of column s takes lane positions 2k (upper) and 2k+1 (lower). Its code sits in bits [2i+1:2i] of the bank, with i = s·N/2 + k.
  - Between columns s and s+1, the lanes are divided into blocks of B lanes. B is N>>s for s < log2(N)−1, and N>>(2·log2(N)−3−s) otherwise.
  - In the first half, local output p of a block moves to (p mod 2)·B/2 + p/2 of the same block. In the second half, it moves to 2·(p mod B/2) + p/(B/2).
  - With every code at 00, the network maps lane j to lane j.
- R4: When `cfg_wr_en` is high and `cfg_wr_idx` is below the element count, the staging code at that index takes `cfg_wr_code` on the next edge. A higher index changes nothing. Staging codes do not affect `dout` until they are loaded.
- R5: A high `cfg_load` copies the staging bank, as it stood before that edge, into the active bank. A write in the same cycle is therefore not copied. Data captured on that same edge still uses the old mapping. Data from the next edge on uses the new one.
- R6: With the output register present (the default), `dout` shows the mapping of the `din` captured on the previous rising edge. The mapping uses the active codes of that cycle.
- R7: Using only codes 00 and 01, every permutation of the N lanes can be produced.
- R8: Copy codes allow mappings that are not permutations:
  - With all codes at 10, every output lane carries input lane 0.
  - With all codes at 11, every output lane carries input lane N−1.
  - Any mix of the four codes gives the mapping defined by R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write one staging code |
| cfg_wr_idx | input | $clog2(NSW) | Element index of the write |
| cfg_wr_code | input | 2 | Control code to store |
| cfg_load | input | 1 | Copy the staging bank into the active bank |
| din | input | N·W | Input lanes, lane j in bits [j·W+W−1 : j·W] |
| dout | output | N·W | Output lanes, same packing |

## Verification
The checker assumes that the write index is either a real element or is deliberately out of range. It also assumes that the bank holds only the four defined codes, which any 2-bit value satisfies. The identity property relies on the output register being present, so the stimulus stays with the default of one register stage. The bench changes configuration only through the write and load pins. It holds `din` stable across each sampling edge and drives every input at the falling edge. The relation between a load and the first beat that uses it therefore never depends on process order.

// File: rtl/benes_pkg.sv
package benes_pkg;

    typedef enum logic [1:0] {
        SW_PASS  = 2'b00,
        SW_SWAP  = 2'b01,
        SW_COPYU = 2'b10,
        SW_COPYL = 2'b11
    } sw_code_e;

    // Number of switch columns for an n-lane network.
    function automatic int column_count(int n);
        return 2 * $clog2(n) - 1;
    endfunction

    // Lane of column s output that feeds lane d of column s+1.
    function automatic int link_src(int n, int s, int d);
        int lg;
        int blk;
        int h;
        int base;
        int r;
        lg   = $clog2(n);
        blk  = (s < lg - 1) ? (n >> s) : (n >> (2 * lg - 3 - s));
        h    = blk / 2;
        base = d - (d % blk);
        r    = d % blk;
        if (s < lg - 1)
            return base + 2 * (r % h) + r / h;
        else
            return base + (r % 2) * h + r / 2;
    endfunction

endpackage

// File: rtl/benes_switch.sv
module benes_switch
    import benes_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] up_i,
    input  logic [W-1:0] lo_i,
    input  sw_code_e     code,
    output logic [W-1:0] up_o,
    output logic [W-1:0] lo_o
);
    always_comb begin
        unique case (code)
            SW_PASS:  begin up_o = up_i; lo_o = lo_i; end
            SW_SWAP:  begin up_o = lo_i; lo_o = up_i; end
            SW_COPYU: begin up_o = up_i; lo_o = up_i; end
            default:  begin up_o = lo_i; lo_o = lo_i; end
        endcase
    end
endmodule

// File: rtl/benes_cfg_regs.sv
module benes_cfg_regs #(
    parameter int NSW = 20,
    parameter int IW  = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [1:0]      wr_code,
    input  logic            load,
    output logic [2*NSW-1:0] staged_o,
    output logic [2*NSW-1:0] active_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            staged_o <= '0;
            active_o <= '0;
        end else begin
            if (load)
                active_o <= staged_o;
            if (wr_en && (int'(wr_idx) < NSW))
                staged_o[int'(wr_idx) * 2 +: 2] <= wr_code;
        end
    end
endmodule

// File: rtl/benes_fabric.sv
module benes_fabric
    import benes_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic [2*(column_count(N)*(N/2))-1:0] codes,
    input  logic [N*W-1:0]                       lanes_i,
    output logic [N*W-1:0]                       lanes_o
);
    localparam int NCOL = column_count(N);
    localparam int NROW = N / 2;

    logic [W-1:0] col_in  [NCOL][N];
    logic [W-1:0] col_out [NCOL][N];

    for (genvar s = 0; s < NCOL; s++) begin : g_col
        for (genvar d = 0; d < N; d++) begin : g_link
            if (s == 0) begin : g_first
                assign col_in[s][d] = lanes_i[d*W +: W];
            end else begin : g_wire
                assign col_in[s][d] = col_out[s-1][link_src(N, s-1, d)];
            end
        end
        for (genvar k = 0; k < NROW; k++) begin : g_row
            benes_switch #(.W(W)) u_sw (
                .up_i (col_in[s][2*k]),
                .lo_i (col_in[s][2*k+1]),
                .code (sw_code_e'(codes[(s*NROW+k)*2 +: 2])),
                .up_o (col_out[s][2*k]),
                .lo_o (col_out[s][2*k+1])
            );
        end
    end

    for (genvar d = 0; d < N; d++) begin : g_out
        assign lanes_o[d*W +: W] = col_out[NCOL-1][d];
    end
endmodule

// File: rtl/benes_net.sv
module benes_net
    import benes_pkg::*;
#(
    parameter int N       = 8,
    parameter int W       = 8,
    parameter int OUT_REG = 1,
    localparam int NSW    = column_count(N) * (N / 2),
    localparam int IW     = $clog2(NSW)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_wr_en,
    input  logic [IW-1:0]   cfg_wr_idx,
    input  logic [1:0]      cfg_wr_code,
    input  logic            cfg_load,
    input  logic [N*W-1:0]  din,
    output logic [N*W-1:0]  dout
);
    logic [2*NSW-1:0] shadow_cfg;
    logic [2*NSW-1:0] active_cfg;
    logic [N*W-1:0]   net_out;

    benes_cfg_regs #(.NSW(NSW), .IW(IW)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr_en),
        .wr_idx   (cfg_wr_idx),
        .wr_code  (cfg_wr_code),
        .load     (cfg_load),
        .staged_o (shadow_cfg),
        .active_o (active_cfg)
    );

    benes_fabric #(.N(N), .W(W)) u_fab (
        .codes   (active_cfg),
        .lanes_i (din),
        .lanes_o (net_out)
    );

    if (OUT_REG != 0) begin : g_reg
        logic [N*W-1:0] dout_q;
        always_ff @(posedge clk) begin
            if (rst) dout_q <= '0;
            else     dout_q <= net_out;
        end
        assign dout = dout_q;
    end else begin : g_comb
        assign dout = net_out;
    end
endmodule

// File: rtl/benes_net_chk.sv
module benes_net_chk #(
    parameter int N       = 8,
    parameter int W       = 8,
    parameter int OUT_REG = 1,
    parameter int NSW     = 20,
    parameter int IW      = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_wr_en,
    input logic [IW-1:0]    cfg_wr_idx,
    input logic [1:0]       cfg_wr_code,
    input logic             cfg_load,
    input logic [N*W-1:0]   din,
    input logic [N*W-1:0]   dout,
    input logic [2*NSW-1:0] shadow_cfg,
    input logic [2*NSW-1:0] active_cfg
);
    logic [IW-1:0] idx_d;
    logic          wr_ok;

    assign wr_ok = cfg_wr_en && (int'(cfg_wr_idx) < NSW);

    always_ff @(posedge clk) idx_d <= cfg_wr_idx;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (active_cfg == '0 && shadow_cfg == '0)); // R1

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_ok |=> shadow_cfg[int'(idx_d) * 2 +: 2] == $past(cfg_wr_code)); // R4

    AST_STAGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_ok |=> $stable(shadow_cfg)); // R4

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> active_cfg == $past(shadow_cfg)); // R5

    AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> $stable(active_cfg)); // R5

    if (OUT_REG != 0) begin : g_reg_chk
        AST_DOUT_CLEARS: assert property (@(posedge clk)
            rst |=> dout == '0); // R1

        AST_PASS_IDENTITY: assert property (@(posedge clk) disable iff (rst)
            (active_cfg == '0) |=> dout == $past(din)); // R6
    end
endmodule

bind benes_net benes_net_chk #(
    .N(N), .W(W), .OUT_REG(OUT_REG), .NSW(NSW), .IW(IW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_idx  (cfg_wr_idx),
    .cfg_wr_code (cfg_wr_code),
    .cfg_load    (cfg_load),
    .din         (din),
    .dout        (dout),
    .shadow_cfg  (shadow_cfg),
    .active_cfg  (active_cfg)
);

// File: tb/tb_benes_net.sv
module tb_benes_net;
    localparam int  N      = 8;
    localparam int  W      = 8;
    localparam int  LG     = 3;
    localparam int  NCOL   = 2 * LG - 1;
    localparam int  NROW   = N / 2;
    localparam int  NSW    = NCOL * NROW;
    localparam int  IW     = 5;
    localparam time PERIOD = 10;

    typedef int lane_t [N];
    typedef int cfg_t  [NSW];

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [IW-1:0]  wr_idx = '0;
    logic [1:0]     wr_code = '0;
    logic           load = 1'b0;
    logic [N*W-1:0] din = '0;
    logic [N*W-1:0] dout;

    always #(PERIOD/2) clk = ~clk;

    benes_net #(.N(N), .W(W), .OUT_REG(1)) dut (
        .clk (clk), .rst (rst),
        .cfg_wr_en (wr_en), .cfg_wr_idx (wr_idx), .cfg_wr_code (wr_code),
        .cfg_load (load), .din (din), .dout (dout)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    done = 1'b0;
    bit    exp_ok = 1'b0;
    int    m_stage [NSW];
    int    m_active [NSW];
    logic [N*W-1:0] exp_vec;

    task automatic chk(bit ok, string t, logic [N*W-1:0] act, logic [N*W-1:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", t, act, expv);
        end
    endtask

    // Destination lane of column s output p (R3 wiring).
    function automatic int fwd_dst(int s, int p);
        int blk, h, base, q;
        blk  = (s < LG - 1) ? (N >> s) : (N >> (2 * LG - 3 - s));
        h    = blk / 2;
        base = p - (p % blk);
        q    = p % blk;
        if (s < LG - 1) return base + (q % 2) * h + q / 2;
        return base + 2 * (q % h) + q / h;
    endfunction

    function automatic void run_net(input lane_t x, input cfg_t c, output lane_t y);
        lane_t v, w;
        v = x;
        for (int s = 0; s < NCOL; s++) begin
            for (int k = 0; k < NROW; k++) begin
                int a, b;
                a = v[2*k];
                b = v[2*k+1];
                case (c[s*NROW+k])
                    0:       begin w[2*k] = a; w[2*k+1] = b; end
                    1:       begin w[2*k] = b; w[2*k+1] = a; end
                    2:       begin w[2*k] = a; w[2*k+1] = a; end
                    default: begin w[2*k] = b; w[2*k+1] = b; end
                endcase
            end
            if (s < NCOL - 1) begin
                for (int p = 0; p < N; p++) v[fwd_dst(s, p)] = w[p];
            end else begin
                v = w;
            end
        end
        y = v;
    endfunction

    // Looping algorithm: codes that send input i to output perm[i].
    function automatic void route_perm(input lane_t perm, output cfg_t c);
        lane_t cur, nxt, side, inv;
        int blk, h, x, j, i0;
        for (int i = 0; i < NSW; i++) c[i] = 0;
        cur = perm;
        for (int s = 0; s < LG; s++) begin
            blk = N >> s;
            h   = blk / 2;
            for (int base = 0; base < N; base += blk) begin
                if (blk == 2) begin
                    c[s*NROW + base/2] = (cur[base] == 0) ? 0 : 1;
                end else begin
                    for (int i = 0; i < blk; i++) begin
                        side[i] = -1;
                        inv[cur[base+i]] = i;
                    end
                    for (int k = 0; k < h; k++) begin
                        if (side[2*k] < 0) begin
                            side[2*k] = 0;
                            side[2*k+1] = 1;
                            x = 2*k;
                            while (1) begin
                                j = inv[cur[base+x] ^ 1];
                                if (side[j] >= 0) break;
                                side[j] = 1 - side[x];
                                side[j^1] = side[x];
                                x = j ^ 1;
                            end
                        end
                    end
                    for (int k = 0; k < h; k++) begin
                        c[s*NROW + base/2 + k] = side[2*k];
                        i0 = (side[2*k] == 0) ? 2*k : 2*k+1;
                        nxt[base+k]   = cur[base+i0] / 2;
                        nxt[base+h+k] = cur[base+(i0^1)] / 2;
                    end
                    for (int i = 0; i < blk; i++) begin
                        if (side[i] == 0)
                            c[(NCOL-1-s)*NROW + base/2 + cur[base+i]/2] = cur[base+i] % 2;
                    end
                end
            end
            if (blk > 2) cur = nxt;
        end
    endfunction

    // Behavioural reference, updated on each rising edge.
    always @(posedge clk) begin : model
        lane_t x, y;
        if (rst) begin
            for (int i = 0; i < NSW; i++) begin m_stage[i] = 0; m_active[i] = 0; end
            exp_vec = '0;
            exp_ok = 1'b1;
        end else begin
            for (int i = 0; i < N; i++) x[i] = int'(din[i*W +: W]);
            run_net(x, m_active, y);
            for (int i = 0; i < N; i++) exp_vec[i*W +: W] = W'(y[i]);
            if (load) m_active = m_stage;
            if (wr_en && int'(wr_idx) < NSW) m_stage[int'(wr_idx)] = int'(wr_code);
        end
    end

    always @(negedge clk) begin
        if (exp_ok && !done) chk(dout === exp_vec, {tag, " model"}, dout, exp_vec);
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rand_din();
        for (int i = 0; i < N; i++) din[i*W +: W] = W'($urandom);
    endtask

    task automatic write_one(int idx, int code);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_code = 2'(code);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic stage_all(cfg_t c);
        for (int i = 0; i < NSW; i++) write_one(i, c[i]);
    endtask

    task automatic load_all(cfg_t c);
        stage_all(c);
        load = 1'b1;
        tick();
        load = 1'b0;
    endtask

    task automatic check_perm(lane_t perm, string t);
        cfg_t c;
        logic [N*W-1:0] e;
        route_perm(perm, c);
        load_all(c);
        for (int r = 0; r < 3; r++) begin
            rand_din();
            tick();
            for (int i = 0; i < N; i++) e[perm[i]*W +: W] = din[i*W +: W];
            chk(dout === e, t, dout, e);
        end
    endtask

    initial begin : watchdog
        #(PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        cfg_t c;
        lane_t perm;
        logic [N*W-1:0] e, a0;
        int t;

        // R1: reset
        tag = "R1";
        for (int r = 0; r < 3; r++) begin rand_din(); tick(); end
        chk(dout === '0, "R1 dout cleared", dout, '0);
        rst = 1'b0;
        rand_din();
        tick();
        chk(dout === din, "R1 identity after reset", dout, din);

        // R2: codes on last-column row 1 (lanes 2,3)
        tag = "R2";
        for (int code = 0; code < 4; code++) begin
            for (int i = 0; i < NSW; i++) c[i] = 0;
            c[(NCOL-1)*NROW + 1] = code;
            load_all(c);
            rand_din();
            tick();
            e = din;
            case (code)
                1: begin e[2*W +: W] = din[3*W +: W]; e[3*W +: W] = din[2*W +: W]; end
                2: e[3*W +: W] = din[2*W +: W];
                3: e[2*W +: W] = din[3*W +: W];
                default: ;
            endcase
            chk(dout === e, $sformatf("R2 code %0d", code), dout, e);
        end

        // R4: staging has no effect before load; bad index ignored
        tag = "R4";
        for (int i = 0; i < NSW; i++) c[i] = 0;
        load_all(c);
        for (int i = 0; i < NSW; i++) c[i] = 1;
        stage_all(c);
        rand_din();
        tick();
        chk(dout === din, "R4 staged not applied", dout, din);
        for (int i = 0; i < NSW; i++) c[i] = 0;
        stage_all(c);
        write_one(31, 1);
        load = 1'b1; tick(); load = 1'b0;
        rand_din();
        tick();
        chk(dout === din, "R4 out-of-range write ignored", dout, din);

        // R5: load timing and write in the load cycle
        tag = "R5";
        for (int i = 0; i < NSW; i++) c[i] = 0;
        c[(NCOL-1)*NROW] = 1;
        stage_all(c);
        rand_din();
        load = 1'b1;
        tick();
        load = 1'b0;
        chk(dout === din, "R5 load-cycle beat uses old map", dout, din);
        rand_din();
        tick();
        e = din;
        e[0 +: W] = din[W +: W];
        e[W +: W] = din[0 +: W];
        chk(dout === e, "R5 next beat uses new map", dout, e);
        for (int i = 0; i < NSW; i++) c[i] = 0;
        stage_all(c);
        wr_en = 1'b1; wr_idx = IW'((NCOL-1)*NROW); wr_code = 2'b01; load = 1'b1;
        rand_din();
        tick();
        wr_en = 1'b0; load = 1'b0;
        rand_din();
        tick();
        chk(dout === din, "R5 same-cycle write not loaded", dout, din);
        load = 1'b1; tick(); load = 1'b0;
        rand_din();
        tick();
        e = din;
        e[0 +: W] = din[W +: W];
        e[W +: W] = din[0 +: W];
        chk(dout === e, "R5 later load picks write", dout, e);

        // R7: permutations
        tag = "R7";
        for (int i = 0; i < N; i++) perm[i] = N - 1 - i;
        check_perm(perm, "R7 reverse");
        for (int i = 0; i < N; i++) perm[i] = (i + 3) % N;
        check_perm(perm, "R7 rotate by 3");
        for (int i = 0; i < N; i++) perm[i] = {i[0], i[1], i[2]};
        check_perm(perm, "R7 bit reverse");
        for (int r = 0; r < 20; r++) begin
            for (int i = 0; i < N; i++) perm[i] = i;
            for (int i = N - 1; i > 0; i--) begin
                int k;
                k = $urandom_range(0, i);
                t = perm[i]; perm[i] = perm[k]; perm[k] = t;
            end
            check_perm(perm, "R7 random permutation");
        end

        // R8: copy codes
        tag = "R8";
        for (int i = 0; i < NSW; i++) c[i] = 2;
        load_all(c);
        rand_din();
        tick();
        a0 = {N{din[0 +: W]}};
        chk(dout === a0, "R8 all copy-upper", dout, a0);
        for (int i = 0; i < NSW; i++) c[i] = 3;
        load_all(c);
        rand_din();
        tick();
        a0 = {N{din[(N-1)*W +: W]}};
        chk(dout === a0, "R8 all copy-lower", dout, a0);

        // R3/R6/R8: random mixed codes against the model
        tag = "R3 R6 R8";
        for (int r = 0; r < 60; r++) begin
            for (int i = 0; i < NSW; i++) c[i] = $urandom_range(0, 3);
            load_all(c);
            for (int b = 0; b < 3; b++) begin rand_din(); tick(); end
        end

        tick();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule